// File: doc/BRIEF.md
# Paired-Channel ADC Self-Calibration Sequencer

Two ADC channels watch the same analog input. This block decides, slot by slot, which of them converts the signal and which one reads one of the two internal reference levels: the ground reference (GIO) or the supply reference (VIO). At any time one channel is calibrating and the other carries the signal. Each channel's GIO and VIO readings go into registers that belong to that channel only. Every signal sample from the channel that is currently delivering output is normalised against that channel's own reference pair by a bit-serial divider. The result is an output stream that keeps up with the raw sample rate while calibration runs in the background.

A slot is one conversion period of the pair. It closes once each channel has raised its strobe once; a second strobe from the same channel within a slot is ignored. After reset, or after `en` rises, the sequencer stays in a warm-up state for a programmable number of clock cycles. It then runs a calibration round. A programmable number of signal-only slots follows each round. A reading taken right after a channel switches mode is thrown away as a settling transient. A reference reading that falls outside its plausibility window is rejected and flagged.

States and transitions: `S_WARM` → `S_B_GND` (B reads GIO, A carries the signal) → `S_B_SUP` (B reads VIO) → `S_B_BACK` (B back on signal and settling) → `S_A_GND` (A reads GIO, B carries the signal) → `S_A_SUP` (A reads VIO) → `S_A_BACK` (A settling, B carries the signal). From there it goes to `S_RUN` (signal-only slots, A carries the signal), or straight back to `S_B_GND` when the gap is zero. `S_RUN` returns to `S_B_GND` when its slots run out. Every state goes to `S_WARM` when `rst` is high or `en` is low.

Top module: `adc_pair_cal_seq`

## Requirements
- R1: Mode outputs use the encoding 0 = signal, 1 = GIO, 2 = VIO. The states follow the cycle listed above. Each reference state lasts SETTLE+1 slots, each settling state lasts SETTLE slots (default SETTLE = 1), and `S_RUN` lasts `cal_gap` slots.
- R2: In every slot at least one channel is in signal mode. The output channel is A in `S_B_GND`, `S_B_SUP`, `S_B_BACK` and `S_RUN`, and B in the three `S_A_*` states.
- R3: A sample from a channel in the first SETTLE slots after its mode changes is discarded. This covers each reference state and the whole settling state that follows. A discarded sample changes neither calibration register nor the output.
- R4: Each channel keeps its own GIO/VIO pair, and its output samples use only that pair.
- R5: A GIO reading outside [G_LO, G_HI] (default 9000..14000) or a VIO reading outside [V_LO, V_HI] (default 52000..57000) is not stored. It raises that channel's bit of `cal_err` (bit 0 = A, bit 1 = B) for one cycle, on the cycle after the strobe.
- R6: While in `S_WARM`, both modes are signal and every strobe is ignored. With `en` high from the cycle after reset, `mode_b` turns to 1 after `warm_cycles`+1 rising edges.
- R7: After `S_A_BACK`, the sequencer runs `cal_gap` signal-only slots with both modes 0 before the next round begins. A gap of 0 starts the next round at once.
- R8: The output value is floor((sig−GIO)·65536/(VIO−GIO)). It is 0 when sig ≤ GIO and saturates at 65535. `out_vld` pulses for one cycle, 16 clock edges after the edge that samples the strobe. Strobes of the output channel must be at least 17 cycles apart.
- R9: No output appears from a channel until both of its references have been captured since the last reset or enable.
- R10: `out_ch` gives the producing channel (0 = A, 1 = B).
- R11: A synchronous active-high `rst` returns to `S_WARM` with both modes 0. It clears all stored references, `out_vld` and `cal_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | ADC pair enabled; low forces warm-up and clears calibration |
| warm_cycles | input | 24 | Warm-up length in clock cycles |
| cal_gap | input | 16 | Signal-only slots between calibration rounds |
| a_stb | input | 1 | Channel A sample strobe |
| a_data | input | 16 | Channel A raw sample |
| b_stb | input | 1 | Channel B sample strobe |
| b_data | input | 16 | Channel B raw sample |
| mode_a | output | 2 | Channel A mode select (0 signal, 1 GIO, 2 VIO) |
| mode_b | output | 2 | Channel B mode select |
| out_vld | output | 1 | Normalised sample valid pulse |
| out_data | output | 16 | Normalised sample |
| out_ch | output | 1 | Channel that produced the sample |
| cal_err | output | 2 | Per-channel rejected-reference pulse |

## Verification
The mode outputs change one cycle after the edge that completes a slot. The bench therefore checks both modes at the falling edge just before it drives each slot's strobes. `cal_err` is due one cycle after the strobe edge and is sampled at the very next falling edge. Each normalised sample is due 16 edges after its strobe edge. The bench queues it with that cycle number and compares the output at every falling edge. A result that arrives early or late, or `out_vld` with nothing queued, is reported.

// File: rtl/adc_cal_pkg.sv
package adc_cal_pkg;

    typedef enum logic [1:0] {
        MODE_SIG = 2'd0,
        MODE_GND = 2'd1,
        MODE_SUP = 2'd2
    } adc_mode_e;

    typedef enum logic [2:0] {
        S_WARM,
        S_B_GND,
        S_B_SUP,
        S_B_BACK,
        S_A_GND,
        S_A_SUP,
        S_A_BACK,
        S_RUN
    } seq_st_e;

    localparam int NCH = 2;

endpackage

// File: rtl/cal_sched.sv
module cal_sched
    import adc_cal_pkg::*;
#(
    parameter int SETTLE = 1,
    parameter int WCW    = 24,
    parameter int GCW    = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           en,
    input  logic [WCW-1:0] warm_cycles,
    input  logic [GCW-1:0] cal_gap,
    input  logic           slot_done,
    output adc_mode_e      mode_a,
    output adc_mode_e      mode_b,
    output logic           keep_a,
    output logic           keep_b,
    output logic           out_sel,
    output logic           active
);

    localparam int SCW = GCW + 1;

    seq_st_e        st, st_nx;
    logic [SCW-1:0] sc;
    logic [SCW-1:0] dwell;
    logic [WCW-1:0] wcnt;
    logic           last;
    logic           cal_slot;
    logic           adv;

    // slots spent in each state
    always_comb begin
        unique case (st)
            S_B_GND, S_B_SUP, S_A_GND, S_A_SUP: dwell = SCW'(SETTLE + 1);
            S_B_BACK, S_A_BACK:                 dwell = SCW'(SETTLE);
            S_RUN:                              dwell = {1'b0, cal_gap};
            S_WARM:                             dwell = SCW'(1);
        endcase
    end

    assign last     = (sc + SCW'(1)) >= dwell;
    assign cal_slot = (sc == SCW'(SETTLE));
    assign adv      = slot_done && last;

    // next state
    always_comb begin
        st_nx = st;
        unique case (st)
            S_WARM:   if (wcnt >= warm_cycles) st_nx = S_B_GND;
            S_B_GND:  if (adv) st_nx = S_B_SUP;
            S_B_SUP:  if (adv) st_nx = S_B_BACK;
            S_B_BACK: if (adv) st_nx = S_A_GND;
            S_A_GND:  if (adv) st_nx = S_A_SUP;
            S_A_SUP:  if (adv) st_nx = S_A_BACK;
            S_A_BACK: if (adv) st_nx = (cal_gap == '0) ? S_B_GND : S_RUN;
            S_RUN:    if (adv) st_nx = S_B_GND;
        endcase
        if (!en) st_nx = S_WARM;
    end

    // state register with slot and warm-up counters
    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= S_WARM;
            sc   <= '0;
            wcnt <= '0;
        end else begin
            st <= st_nx;
            if (st == S_WARM || !en)
                sc <= '0;
            else if (slot_done)
                sc <= last ? '0 : sc + SCW'(1);
            if (st == S_WARM && st_nx == S_WARM && en)
                wcnt <= wcnt + WCW'(1);
            else
                wcnt <= '0;
        end
    end

    // outputs decoded from state
    always_comb begin
        mode_a  = MODE_SIG;
        mode_b  = MODE_SIG;
        keep_a  = 1'b1;
        keep_b  = 1'b1;
        out_sel = 1'b0;
        active  = 1'b1;
        unique case (st)
            S_WARM: begin
                keep_a = 1'b0;
                keep_b = 1'b0;
                active = 1'b0;
            end
            S_B_GND: begin
                mode_b = MODE_GND;
                keep_b = cal_slot;
            end
            S_B_SUP: begin
                mode_b = MODE_SUP;
                keep_b = cal_slot;
            end
            S_B_BACK: keep_b = 1'b0;
            S_A_GND: begin
                mode_a  = MODE_GND;
                keep_a  = cal_slot;
                out_sel = 1'b1;
            end
            S_A_SUP: begin
                mode_a  = MODE_SUP;
                keep_a  = cal_slot;
                out_sel = 1'b1;
            end
            S_A_BACK: begin
                keep_a  = 1'b0;
                out_sel = 1'b1;
            end
            S_RUN: ;
        endcase
    end

    AST_ONE_SIG: assert property (@(posedge clk) disable iff (rst)
        (mode_a == MODE_SIG) || (mode_b == MODE_SIG)); // R2

    AST_OUT_CH_SIG: assert property (@(posedge clk) disable iff (rst)
        active |-> ((out_sel ? mode_b : mode_a) == MODE_SIG)
                   && (out_sel ? keep_b : keep_a)); // R2

    AST_B_GND_TO_SUP: assert property (@(posedge clk) disable iff (rst)
        (en && $past(st) == S_B_GND && st != S_B_GND) |-> st == S_B_SUP); // R1

    AST_A_GND_TO_SUP: assert property (@(posedge clk) disable iff (rst)
        (en && $past(st) == S_A_GND && st != S_A_GND) |-> st == S_A_SUP); // R1

    AST_B_SETTLE: assert property (@(posedge clk) disable iff (rst)
        (mode_b != $past(mode_b)) |-> !keep_b); // R3

    AST_A_SETTLE: assert property (@(posedge clk) disable iff (rst)
        (mode_a != $past(mode_a)) |-> !keep_a); // R3

    AST_WARM_QUIET: assert property (@(posedge clk) disable iff (rst)
        (st == S_WARM) |-> (!keep_a && !keep_b && mode_a == MODE_SIG
                            && mode_b == MODE_SIG)); // R6

endmodule

// File: rtl/cal_store.sv
module cal_store #(
    parameter int W    = 16,
    parameter int G_LO = 9000,
    parameter int G_HI = 14000,
    parameter int V_LO = 52000,
    parameter int V_HI = 57000
) (
    input  logic         clk,
    input  logic         clr,
    input  logic         wr_gnd,
    input  logic         wr_sup,
    input  logic [W-1:0] din,
    output logic [W-1:0] gnd_val,
    output logic [W-1:0] sup_val,
    output logic         ready,
    output logic         err
);

    localparam logic [W-1:0] GLO = W'(G_LO);
    localparam logic [W-1:0] GHI = W'(G_HI);
    localparam logic [W-1:0] VLO = W'(V_LO);
    localparam logic [W-1:0] VHI = W'(V_HI);

    logic have_g, have_v;
    logic g_ok, v_ok;

    assign g_ok  = (din >= GLO) && (din <= GHI);
    assign v_ok  = (din >= VLO) && (din <= VHI);
    assign ready = have_g && have_v;

    always_ff @(posedge clk) begin
        if (clr) begin
            gnd_val <= '0;
            sup_val <= '0;
            have_g  <= 1'b0;
            have_v  <= 1'b0;
            err     <= 1'b0;
        end else begin
            err <= 1'b0;
            if (wr_gnd) begin
                if (g_ok) begin
                    gnd_val <= din;
                    have_g  <= 1'b1;
                end else begin
                    err <= 1'b1;
                end
            end
            if (wr_sup) begin
                if (v_ok) begin
                    sup_val <= din;
                    have_v  <= 1'b1;
                end else begin
                    err <= 1'b1;
                end
            end
        end
    end

    AST_GND_IN_WINDOW: assert property (@(posedge clk) disable iff (clr)
        have_g |-> (gnd_val >= GLO && gnd_val <= GHI)); // R5

    AST_SUP_IN_WINDOW: assert property (@(posedge clk) disable iff (clr)
        have_v |-> (sup_val >= VLO && sup_val <= VHI)); // R5

    AST_ERR_NO_STORE: assert property (@(posedge clk) disable iff (clr)
        err |-> ($stable(gnd_val) && $stable(sup_val))); // R5

endmodule

// File: rtl/norm_div.sv
module norm_div #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         clr,
    input  logic         go,
    input  logic [W-1:0] sig,
    input  logic [W-1:0] gnd,
    input  logic [W-1:0] sup,
    input  logic         tag_in,
    output logic         out_vld,
    output logic [W-1:0] out_q,
    output logic         out_tag
);

    localparam int CNTW = $clog2(W + 1);

    logic [W-1:0]    diff, den_in;
    logic [W-1:0]    rem, den, quo;
    logic [W:0]      shifted;
    logic            ge;
    logic [W-1:0]    rem_nx;
    logic [CNTW-1:0] cnt;
    logic            busy, sat, tag;

    assign diff    = (sig > gnd) ? sig - gnd : '0;
    assign den_in  = sup - gnd;
    assign shifted = {rem, 1'b0};
    assign ge      = shifted >= {1'b0, den};
    assign rem_nx  = ge ? W'(shifted - {1'b0, den}) : shifted[W-1:0];

    always_ff @(posedge clk) begin
        if (clr) begin
            busy    <= 1'b0;
            cnt     <= '0;
            rem     <= '0;
            den     <= '0;
            quo     <= '0;
            sat     <= 1'b0;
            tag     <= 1'b0;
            out_vld <= 1'b0;
            out_q   <= '0;
            out_tag <= 1'b0;
        end else begin
            out_vld <= 1'b0;
            if (go) begin
                rem  <= diff;
                den  <= den_in;
                sat  <= diff >= den_in;
                quo  <= '0;
                cnt  <= CNTW'(W);
                busy <= 1'b1;
                tag  <= tag_in;
            end else if (busy) begin
                rem <= rem_nx;
                quo <= {quo[W-2:0], ge};
                cnt <= cnt - CNTW'(1);
                if (cnt == CNTW'(1)) begin
                    busy    <= 1'b0;
                    out_vld <= 1'b1;
                    out_q   <= sat ? '1 : {quo[W-2:0], ge};
                    out_tag <= tag;
                end
            end
        end
    end

    AST_DIV_FREE: assert property (@(posedge clk) disable iff (clr)
        go |-> !busy); // R8

    AST_DEN_POSITIVE: assert property (@(posedge clk) disable iff (clr)
        go |-> (sup > gnd)); // R4

    AST_DIV_DONE: assert property (@(posedge clk) disable iff (clr)
        out_vld |-> ($past(busy) && !busy)); // R8

endmodule

// File: rtl/adc_pair_cal_seq.sv
module adc_pair_cal_seq
    import adc_cal_pkg::*;
#(
    parameter int W      = 16,
    parameter int SETTLE = 1,
    parameter int WCW    = 24,
    parameter int GCW    = 16,
    parameter int G_LO   = 9000,
    parameter int G_HI   = 14000,
    parameter int V_LO   = 52000,
    parameter int V_HI   = 57000
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           en,
    input  logic [WCW-1:0] warm_cycles,
    input  logic [GCW-1:0] cal_gap,
    input  logic           a_stb,
    input  logic [W-1:0]   a_data,
    input  logic           b_stb,
    input  logic [W-1:0]   b_data,
    output logic [1:0]     mode_a,
    output logic [1:0]     mode_b,
    output logic           out_vld,
    output logic [W-1:0]   out_data,
    output logic           out_ch,
    output logic [1:0]     cal_err
);

    adc_mode_e        md_a, md_b;
    logic             keep_a, keep_b, out_sel, active;
    logic             clr;
    logic [NCH-1:0]   stb, keep, got, take, wr_g, wr_v, rdy;
    logic [1:0]       md  [NCH];
    logic [W-1:0]     dat [NCH];
    logic [W-1:0]     gv  [NCH];
    logic [W-1:0]     sv  [NCH];
    logic             slot_done;
    logic             go;

    assign clr    = rst || !en;
    assign mode_a = md_a;
    assign mode_b = md_b;

    assign stb    = {b_stb, a_stb};
    assign keep   = {keep_b, keep_a};
    assign md[0]  = md_a;
    assign md[1]  = md_b;
    assign dat[0] = a_data;
    assign dat[1] = b_data;

    assign take      = stb & ~got & {NCH{active}};
    assign slot_done = active && (got[0] || take[0]) && (got[1] || take[1]);

    always_ff @(posedge clk) begin
        if (clr || !active || slot_done)
            got <= '0;
        else
            got <= got | take;
    end

    cal_sched #(
        .SETTLE (SETTLE),
        .WCW    (WCW),
        .GCW    (GCW)
    ) u_sched (
        .clk         (clk),
        .rst         (rst),
        .en          (en),
        .warm_cycles (warm_cycles),
        .cal_gap     (cal_gap),
        .slot_done   (slot_done),
        .mode_a      (md_a),
        .mode_b      (md_b),
        .keep_a      (keep_a),
        .keep_b      (keep_b),
        .out_sel     (out_sel),
        .active      (active)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        assign wr_g[i] = take[i] && keep[i] && (md[i] == MODE_GND);
        assign wr_v[i] = take[i] && keep[i] && (md[i] == MODE_SUP);

        cal_store #(
            .W    (W),
            .G_LO (G_LO),
            .G_HI (G_HI),
            .V_LO (V_LO),
            .V_HI (V_HI)
        ) u_store (
            .clk     (clk),
            .clr     (clr),
            .wr_gnd  (wr_g[i]),
            .wr_sup  (wr_v[i]),
            .din     (dat[i]),
            .gnd_val (gv[i]),
            .sup_val (sv[i]),
            .ready   (rdy[i]),
            .err     (cal_err[i])
        );

        AST_DISCARD_KEEPS_CAL: assert property (@(posedge clk) disable iff (clr)
            (take[i] && !keep[i]) |=> ($stable(gv[i]) && $stable(sv[i]))); // R3
    end

    assign go = take[out_sel] && keep[out_sel]
             && (md[out_sel] == MODE_SIG) && rdy[out_sel];

    norm_div #(
        .W (W)
    ) u_div (
        .clk     (clk),
        .clr     (clr),
        .go      (go),
        .sig     (dat[out_sel]),
        .gnd     (gv[out_sel]),
        .sup     (sv[out_sel]),
        .tag_in  (out_sel),
        .out_vld (out_vld),
        .out_q   (out_data),
        .out_tag (out_ch)
    );

    AST_OUT_NEEDS_CAL: assert property (@(posedge clk) disable iff (clr)
        out_vld |-> rdy[out_ch]); // R9

    AST_WARM_NO_TAKE: assert property (@(posedge clk) disable iff (rst)
        !active |-> (wr_g == '0 && wr_v == '0 && !go)); // R6

endmodule

// File: tb/adc_pair_cal_seq_tb.sv
module adc_pair_cal_seq_tb;

    localparam int S   = 1;
    localparam int GLO = 9000;
    localparam int GHI = 14000;
    localparam int VLO = 52000;
    localparam int VHI = 57000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en  = 1'b0;
    logic [23:0] warm_cycles = 24'd10;
    logic [15:0] cal_gap = 16'd3;
    logic        a_stb = 1'b0, b_stb = 1'b0;
    logic [15:0] a_data = '0, b_data = '0;
    logic [1:0]  mode_a, mode_b;
    logic        out_vld;
    logic [15:0] out_data;
    logic        out_ch;
    logic [1:0]  cal_err;

    adc_pair_cal_seq u_dut (
        .clk(clk), .rst(rst), .en(en), .warm_cycles(warm_cycles),
        .cal_gap(cal_gap), .a_stb(a_stb), .a_data(a_data),
        .b_stb(b_stb), .b_data(b_data), .mode_a(mode_a), .mode_b(mode_b),
        .out_vld(out_vld), .out_data(out_data), .out_ch(out_ch),
        .cal_err(cal_err)
    );

    always #2 clk = ~clk;

    int     checks = 0;
    int     errors = 0;
    longint cyc = 0;
    bit     mon_on = 1'b0;
    bit     finished = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    typedef struct { longint due; int val; int ch; } exp_t;
    exp_t q[$];

    int mg[2], mv[2];
    bit hg[2], hv[2];
    int good_g[2] = '{11000, 12500};
    int good_v[2] = '{54000, 55500};

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    function automatic int norm(input int s, input int g, input int v);
        int d, den;
        d   = (s > g) ? s - g : 0;
        den = v - g;
        if (d >= den) return 65535;
        return int'((longint'(d) << 16) / den);
    endfunction

    // slot plan computed from the schedule arithmetic
    task automatic plan_slot(input int t, input int gap, output int ma, output int mb,
                             output bit ka, output bit kb, output int osel);
        int L, p, o1, o2, o3, o4, o5, o6;
        o1 = S + 1; o2 = o1 + S + 1; o3 = o2 + S;
        o4 = o3 + S + 1; o5 = o4 + S + 1; o6 = o5 + S;
        L = o6 + gap;
        p = t % L;
        ma = 0; mb = 0; ka = 1; kb = 1; osel = 0;
        if (p < o1)      begin mb = 1; kb = (p == o1 - 1); end
        else if (p < o2) begin mb = 2; kb = (p == o2 - 1); end
        else if (p < o3) begin kb = 0; end
        else if (p < o4) begin ma = 1; ka = (p == o4 - 1); osel = 1; end
        else if (p < o5) begin ma = 2; ka = (p == o5 - 1); osel = 1; end
        else if (p < o6) begin ka = 0; osel = 1; end
    endtask

    always @(negedge clk) begin
        if (mon_on) begin
            if (q.size() > 0 && q[0].due == cyc) begin
                chk(out_vld == 1'b1, "R8", "out_vld at due cycle", out_vld, 1);
                chk(int'(out_data) == q[0].val, "R4,R8", "out_data", out_data, q[0].val);
                chk(int'(out_ch) == q[0].ch, "R10", "out_ch", out_ch, q[0].ch);
                q.delete(0);
            end else begin
                chk(out_vld == 1'b0, "R9", "unexpected out_vld", out_vld, 0);
            end
        end
    end

    task automatic clear_model();
        for (int c = 0; c < 2; c++) begin
            hg[c] = 0; hv[c] = 0; mg[c] = 0; mv[c] = 0;
        end
    endtask

    // leave reset, enable, and time the warm-up (R6); strobes must be ignored
    task automatic warm_up(input int n);
        rst = 1'b0; en = 1'b1;
        a_stb = 1'b1; b_stb = 1'b1; a_data = 16'd11000; b_data = 16'd55000;
        for (int j = 1; j <= n; j++) begin
            @(negedge clk);
            chk(mode_b == 2'd0, "R6", "mode_b during warm-up", mode_b, 0);
            chk(mode_a == 2'd0, "R6", "mode_a during warm-up", mode_a, 0);
        end
        @(negedge clk);
        chk(mode_b == 2'd1, "R6", "mode_b right after warm-up", mode_b, 1);
    endtask

    task automatic run_slots(input int n, input int gap);
        int ma, mb, osel, L, r, val, m;
        bit ka, kb, k, bad;
        int dv[2];
        logic [1:0] experr;
        L = 4 * (S + 1) + 2 * S + gap;
        for (int t = 0; t < n; t++) begin
            plan_slot(t, gap, ma, mb, ka, kb, osel);
            r = t / L;
            chk(int'(mode_a) == ma, "R1", "mode_a", mode_a, ma);
            chk(int'(mode_b) == mb, "R1", "mode_b", mode_b, mb);
            chk(mode_a == 2'd0 || mode_b == 2'd0, "R2", "no channel on signal",
                {mode_a, mode_b}, 0);
            if ((t % L) >= L - gap && gap > 0)
                chk(mode_a == 2'd0 && mode_b == 2'd0, "R7", "gap slot modes",
                    {mode_a, mode_b}, 0);
            experr = '0;
            for (int c = 0; c < 2; c++) begin
                m   = (c == 0) ? ma : mb;
                k   = (c == 0) ? ka : kb;
                bad = (r == 1) && k && ((c == 1 && m == 1) || (c == 0 && m == 2));
                if (m == 1)      val = k ? (bad ? 20000 : good_g[c]) : 10000;
                else if (m == 2) val = k ? (bad ? 40000 : good_v[c]) : 53500;
                else if (!k)     val = 60000;
                else if (c == osel) val = (t * 7919 + 3000) % 65536;
                else             val = 33333;
                dv[c] = val;
                if (k && m == 1) begin
                    if (val < GLO || val > GHI) experr[c] = 1'b1;
                    else begin mg[c] = val; hg[c] = 1; end
                end
                if (k && m == 2) begin
                    if (val < VLO || val > VHI) experr[c] = 1'b1;
                    else begin mv[c] = val; hv[c] = 1; end
                end
                if (c == osel && k && m == 0 && hg[c] && hv[c])
                    q.push_back('{cyc + 17, norm(val, mg[c], mv[c]), c});
            end
            a_stb = 1'b1; b_stb = 1'b1;
            a_data = 16'(dv[0]); b_data = 16'(dv[1]);
            @(negedge clk);
            a_stb = 1'b0; b_stb = 1'b0;
            chk(cal_err == experr, "R5", "cal_err", cal_err, experr);
            repeat (18) @(negedge clk);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL R8 watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        clear_model();
        repeat (4) @(negedge clk);
        chk(out_vld == 1'b0, "R11", "out_vld in reset", out_vld, 0);
        chk(mode_a == 2'd0 && mode_b == 2'd0, "R11", "modes in reset", {mode_a, mode_b}, 0);
        chk(cal_err == 2'b00, "R11", "cal_err in reset", cal_err, 0);
        mon_on = 1'b1;

        // phase 1: gap of three signal-only slots, bad readings in round 1
        warm_cycles = 24'd10; cal_gap = 16'd3;
        warm_up(10);
        run_slots(39, 3);
        repeat (20) @(negedge clk);
        chk(q.size() == 0, "R8", "results still owed", q.size(), 0);

        // mid-run reset clears calibration (R11)
        rst = 1'b1;
        @(negedge clk);
        chk(mode_a == 2'd0 && mode_b == 2'd0, "R11", "modes after reset", {mode_a, mode_b}, 0);
        chk(out_vld == 1'b0, "R11", "out_vld after reset", out_vld, 0);
        repeat (2) @(negedge clk);
        clear_model();

        // phase 2: zero gap, rounds back to back, output gated until calibrated (R9)
        warm_cycles = 24'd5; cal_gap = 16'd0;
        warm_up(5);
        run_slots(20, 0);
        repeat (20) @(negedge clk);
        chk(q.size() == 0, "R8", "results still owed", q.size(), 0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule